// File: doc/BRIEF.md
# Inter-core mailbox bank

This block holds a bank of 32-bit mailboxes used by processor cores to signal one another. The default build has four cores with four mailboxes each, sixteen in all. Mailbox `i` belongs to core `i / 4` as that core's mailbox `i % 4`. A sender never overwrites a mailbox. It writes a mask to the mailbox's set alias, and those bits are ORed in. The owner reads the mailbox at its clear alias and then writes back the bits it has handled, which removes them.

Each mailbox drives one pending level that is high while any of its bits is one. The levels form a 16-bit vector. The downstream interrupt router places a core's four mailbox levels in bits 4 to 7 of that core's source word. Routing and masking are outside this block.

The block has `NUM_WR` write ports, two by default, and one combinational read port. This lets two agents post to, or clear, the same mailbox in one cycle, with a fixed merge rule.

Top module: `mbx_bank`

## Requirements
- R1: After reset every mailbox reads zero and `pend_o` is all zeros.
- R2: An aligned write to byte offset 0x80 + 4·i sets mailbox `i` to its old value ORed with the write data. Here `i` = core·4 + slot. Bits that are zero in the data keep their old value.
- R3: An aligned write to byte offset 0xC0 + 4·i clears, in mailbox `i`, every bit that is one in the write data. All other bits are unchanged.
- R4: A read at 0xC0 + 4·i returns mailbox `i` in the same cycle, with no register on the read path. If a write lands on that mailbox in the same cycle, the read returns the value from before the write, and the new value appears after the clock edge.
- R5: A read at any offset outside 0xC0–0xFF returns zero. This includes the set window 0x80–0xBF, offsets below 0x80, and offsets whose two low bits are nonzero.
- R6: `pend_o[i]` is high exactly when mailbox `i` is nonzero. It changes on the clock edge that updates the mailbox.
- R7: A set and a clear to the same mailbox in one cycle, on different ports, give (old | set) & ~clear, whichever port carries which.
- R8: Two sets to the same mailbox in one cycle give the old value ORed with both data words.
- R9: A write whose offset has its two low bits nonzero, or that lies below 0x80, changes no mailbox.
- R10: Writes to different mailboxes in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | NUM_WR | Write strobe per write port |
| wr_addr_i | input | NUM_WR×AW | Byte offset per write port |
| wr_data_i | input | NUM_WR×DW | Write data per write port |
| rd_addr_i | input | AW | Byte offset of the read port |
| rd_data_o | output | DW | Read data, combinational |
| pend_o | output | NUM_CORES×MBX_PER_CORE | Per-mailbox nonzero level |

## Verification
Two functions can land on the same mailbox in one cycle. The first is a set and a clear arriving on different ports. The bench drives both, with the port roles swapped between runs, so that some bits are in both masks. It then requires (old | set) & ~clear and the matching pending level. The second is a clear write and a read of the same mailbox. Here the bench checks that the read shows the old contents before the edge and the cleared contents after it. Two simultaneous sets, and two writes to different mailboxes, are also driven together and judged against a bench-side model.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  localparam int unsigned BYTES_PER_MBX = 4;

  // aligned hit inside [base, base + n*4)
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] base,
                                     input int unsigned n);
    return (a[1:0] == 2'b00) && (a >= base) &&
           (a < base + n * BYTES_PER_MBX);
  endfunction
endpackage

// File: rtl/mbx_port_dec.sv
`timescale 1ns/1ps
module mbx_port_dec #(
  parameter int unsigned AW       = 8,
  parameter int unsigned NMBX     = 16,
  parameter int unsigned SET_BASE = 32'h80,
  parameter int unsigned CLR_BASE = 32'hC0,
  localparam int unsigned IW      = $clog2(NMBX)
) (
  input  logic [AW-1:0] addr_i,
  output logic          set_hit_o,
  output logic          clr_hit_o,
  output logic [IW-1:0] idx_o
);
  import mbx_pkg::*;

  logic [31:0] a32;
  logic [31:0] off;

  always_comb begin
    a32       = 32'(addr_i);
    set_hit_o = in_window(a32, SET_BASE, NMBX);
    clr_hit_o = in_window(a32, CLR_BASE, NMBX);
    off       = set_hit_o ? (a32 - SET_BASE) : (a32 - CLR_BASE);
    idx_o     = IW'(off >> 2);
  end
endmodule

// File: rtl/mbx_cell.sv
`timescale 1ns/1ps
module mbx_cell #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  output logic [DW-1:0] q_o,
  output logic          pend_o
);
  // clear applied after set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o | set_i) & ~clr_i;
  end

  assign pend_o = |q_o;

  p_set_sticks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0 && clr_i == '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  p_clear_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/mbx_rd_mux.sv
`timescale 1ns/1ps
module mbx_rd_mux #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NMBX = 16,
  localparam int unsigned IW  = $clog2(NMBX)
) (
  input  logic                     hit_i,
  input  logic [IW-1:0]            idx_i,
  input  logic [NMBX-1:0][DW-1:0]  mbx_i,
  output logic [DW-1:0]            data_o
);
  always_comb begin
    data_o = '0;
    if (hit_i) data_o = mbx_i[idx_i];
  end
endmodule

// File: rtl/mbx_bank.sv
`timescale 1ns/1ps
module mbx_bank #(
  parameter int unsigned NUM_CORES     = 4,
  parameter int unsigned MBX_PER_CORE  = 4,
  parameter int unsigned NUM_WR        = 2,
  parameter int unsigned DW            = 32,
  parameter int unsigned AW            = 8,
  parameter int unsigned SET_BASE      = 32'h80,
  parameter int unsigned CLR_BASE      = 32'hC0,
  localparam int unsigned NMBX         = NUM_CORES * MBX_PER_CORE,
  localparam int unsigned IW           = $clog2(NMBX)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_WR-1:0]           wr_en_i,
  input  logic [NUM_WR-1:0][AW-1:0]   wr_addr_i,
  input  logic [NUM_WR-1:0][DW-1:0]   wr_data_i,
  input  logic [AW-1:0]               rd_addr_i,
  output logic [DW-1:0]               rd_data_o,
  output logic [NMBX-1:0]             pend_o
);
  logic [NUM_WR-1:0]           w_set, w_clr;
  logic [NUM_WR-1:0][IW-1:0]   w_idx;
  logic [NMBX-1:0][DW-1:0]     mbx_q;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wdec
    mbx_port_dec #(.AW(AW), .NMBX(NMBX), .SET_BASE(SET_BASE),
                   .CLR_BASE(CLR_BASE)) u_dec (
      .addr_i    (wr_addr_i[p]),
      .set_hit_o (w_set[p]),
      .clr_hit_o (w_clr[p]),
      .idx_o     (w_idx[p])
    );
  end

  for (genvar m = 0; m < NMBX; m++) begin : g_mbx
    logic [DW-1:0] set_m, clr_m;

    // merge all ports targeting this mailbox
    always_comb begin
      set_m = '0;
      clr_m = '0;
      for (int p = 0; p < NUM_WR; p++) begin
        if (wr_en_i[p] && w_idx[p] == IW'(m)) begin
          if (w_set[p]) set_m |= wr_data_i[p];
          if (w_clr[p]) clr_m |= wr_data_i[p];
        end
      end
    end

    mbx_cell #(.DW(DW)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_m),
      .clr_i  (clr_m),
      .q_o    (mbx_q[m]),
      .pend_o (pend_o[m])
    );
  end

  logic          r_set, r_clr;
  logic [IW-1:0] r_idx;

  mbx_port_dec #(.AW(AW), .NMBX(NMBX), .SET_BASE(SET_BASE),
                 .CLR_BASE(CLR_BASE)) u_rdec (
    .addr_i    (rd_addr_i),
    .set_hit_o (r_set),
    .clr_hit_o (r_clr),
    .idx_o     (r_idx)
  );

  mbx_rd_mux #(.DW(DW), .NMBX(NMBX)) u_rmux (
    .hit_i  (r_clr),
    .idx_i  (r_idx),
    .mbx_i  (mbx_q),
    .data_o (rd_data_o)
  );

  p_rd_pend_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_clr |-> ((rd_data_o != '0) == pend_o[r_idx]));

  p_rd_setwin_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_set |-> (rd_data_o == '0));
endmodule

// File: tb/sim_mbx_bank.sv
`timescale 1ns/1ps
module sim_mbx_bank;
  localparam int NW = 2;
  localparam int NM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NW-1:0]        wr_en = '0;
  logic [NW-1:0][7:0]   wr_addr = '0;
  logic [NW-1:0][31:0]  wr_data = '0;
  logic [7:0]           rd_addr = '0;
  logic [31:0]          rd_data;
  logic [NM-1:0]        pend;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mdl [NM];

  mbx_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .pend_o(pend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input int p, input logic [7:0] a, input logic [31:0] d);
    wr_en[p] = 1'b1; wr_addr[p] = a; wr_data[p] = d;
  endtask

  task automatic commit();
    step();
    wr_en = '0;
  endtask

  task automatic chk_all(input string tag);
    logic [NM-1:0] ep;
    for (int i = 0; i < NM; i++) begin
      rd_addr = 8'(8'hC0 + i * 4);
      #0.1;
      chk(tag, rd_data, mdl[i]);
      ep[i] = (mdl[i] != 0);
    end
    chk({tag, " pend R6"}, 32'(pend), 32'(ep));
  endtask

  task automatic t_reset();
    for (int i = 0; i < NM; i++) mdl[i] = '0;
    chk_all("R1 reset");
  endtask

  task automatic t_set();
    drive(0, 8'h80 + 8'(4 * 6), 32'h0000_00A5); commit();
    mdl[6] |= 32'h0000_00A5;
    drive(0, 8'h80 + 8'(4 * 6), 32'h0F00_0000); commit();
    mdl[6] |= 32'h0F00_0000;
    drive(1, 8'hBC, 32'h8000_0001); commit();
    mdl[15] |= 32'h8000_0001;
    chk_all("R2 set/R4 read");
  endtask

  task automatic t_clear();
    drive(1, 8'hC0 + 8'(4 * 6), 32'h0000_00A0); commit();
    mdl[6] &= ~32'h0000_00A0;
    chk_all("R3 partial clear");
    drive(0, 8'hFC, 32'hFFFF_FFFF); commit();
    mdl[15] = '0;
    chk_all("R3 full clear R6");
  endtask

  task automatic t_collide();
    drive(0, 8'h80 + 8'(4 * 2), 32'h0000_0001); commit();
    mdl[2] = 32'h1;
    drive(0, 8'h80 + 8'(4 * 2), 32'h0000_00FF);
    drive(1, 8'hC0 + 8'(4 * 2), 32'h0000_000F); commit();
    mdl[2] = 32'h0000_00F0;
    chk_all("R7 set p0 clr p1");
    drive(0, 8'hC0 + 8'(4 * 2), 32'h0000_00F0);
    drive(1, 8'h80 + 8'(4 * 2), 32'h0000_01F0); commit();
    mdl[2] = 32'h0000_0100;
    chk_all("R7 clr p0 set p1");
  endtask

  task automatic t_dual();
    drive(0, 8'h80 + 8'(4 * 9), 32'h1234_0000);
    drive(1, 8'h80 + 8'(4 * 9), 32'h0000_5678); commit();
    mdl[9] |= 32'h1234_5678;
    chk_all("R8 dual set");
    drive(0, 8'h80, 32'hCAFE_0000);
    drive(1, 8'h80 + 8'(4 * 13), 32'h0000_BEEF); commit();
    mdl[0] |= 32'hCAFE_0000; mdl[13] |= 32'h0000_BEEF;
    chk_all("R10 distinct");
  endtask

  task automatic t_ignore();
    drive(0, 8'h81, 32'hFFFF_FFFF);
    drive(1, 8'h40, 32'hFFFF_FFFF); commit();
    drive(0, 8'hC2, 32'hFFFF_FFFF);
    drive(1, 8'h7C, 32'hFFFF_FFFF); commit();
    chk_all("R9 ignored writes");
    rd_addr = 8'h80 + 8'(4 * 9); #0.1;
    chk("R5 set window read", rd_data, 32'h0);
    rd_addr = 8'h24; #0.1;
    chk("R5 low offset read", rd_data, 32'h0);
    rd_addr = 8'hC1; #0.1;
    chk("R5 misaligned read", rd_data, 32'h0);
  endtask

  task automatic t_rd_wr_same();
    rd_addr = 8'hC0 + 8'(4 * 9);
    drive(0, 8'hC0 + 8'(4 * 9), 32'hFFFF_0000);
    #0.1;
    chk("R4 read before edge", rd_data, mdl[9]);
    commit();
    mdl[9] &= ~32'hFFFF_0000;
    chk("R4 read after edge", rd_data, mdl[9]);
    chk("R6 pend after edge", 32'(pend[9]), 32'(mdl[9] != 0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_set();
    t_clear();
    t_collide();
    t_dual();
    t_ignore();
    t_rd_wr_same();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule